// File: doc/BRIEF.md
# Suspend/Resume SMI Controller

This block keeps track of the power mode of a small system and turns a single pushbutton into alternating suspend and resume requests. The button is first synchronised and edge-detected, so each press counts once. A press while the system runs at full speed is a suspend request: the mode drops to Suspend at once. A press while the system is in any low-power mode (Sleep, Suspend or Off) is a wake request. The wake does not take effect at once. The controller waits for the next DRAM refresh strobe and then jumps straight to High-Speed, skipping any intermediate mode.

Each request sets its own bit in an event register and raises a system-management interrupt request. Software services the interrupt through a small indexed register port. A write to the status index drops the request line. Event bits are cleared by writing ones to them. An end-of-handler pulse re-arms the request logic. Events that arrive while a handler is running are kept. If any are still set when the handler ends, a new request is raised. Software may also place the system in a low-power mode by writing the mode index.

Top module: `susres_smi_ctrl`

## Requirements
- R1: After reset the mode output is High-Speed (code 2'b00), the event register reads 0, smi_req is low and the first button edge is a suspend request.
- R2: A button rising edge while the mode is High-Speed sets the mode to Suspend (code 2'b10) and sets the suspend event bit (bit 1 of the event register).
- R3: A button rising edge while the mode is Sleep (2'b01), Suspend (2'b10) or Off (2'b11) sets the resume event bit (bit 0) and leaves the mode unchanged until the next refresh strobe. That strobe sets the mode directly to High-Speed. No other cause moves a low-power mode to High-Speed, apart from a software write to the mode index.
- R4: After a resume edge, the next button edge is a suspend request, even when it arrives before the refresh strobe. In that case the pending wake is cancelled and the mode stays Suspend.
- R5: smi_req rises only while at least one event bit is set and the request logic is armed. Once high, it stays high until the status index is written.
- R6: A write to the status index (1) drops smi_req on the next clock. No new request is raised until an end-of-handler pulse arrives, even if new events arrive in the meantime.
- R7: handler_done re-arms the request logic. If any event bit is still set, smi_req rises again.
- R8: A write to the event index (2) clears exactly the event bits written as 1. Events that arrive during service are recorded, and a set bit is never lost except through such a write.
- R9: A button held high for many cycles gives exactly one request.
- R10: A write to the mode index (0) loads bits [1:0] of the write data as the mode code, unless a wake is waiting for its refresh strobe. In that case the write is ignored.
- R11: Reads return the mode code at index 0, smi_req in bit 0 at index 1, the event bits at index 2, and 0 at any other index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_in | input | 1 | Asynchronous suspend/resume pushbutton |
| refresh_stb | input | 1 | One-cycle DRAM refresh strobe |
| reg_idx | input | 4 | Register index |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_idx |
| handler_done | input | 1 | End-of-handler pulse, re-arms requests |
| smi_req | output | 1 | System-management interrupt request |
| mode | output | 2 | Current power mode code |

## Verification
A table of button, refresh and mode-write steps drives the mode machine through three kinds of sequence. Suspend followed by wake shows that the mode change waits for the strobe. A second press before the strobe separates cancel-to-suspend from wake. Wakes from Sleep and Off show that every low-power mode returns straight to High-Speed. Directed sequences then check the request line. An event arriving after the status write must not raise a request until the handler ends, which separates arming from level triggering. A partial clear must leave the other bit set. A long button hold followed by a refresh separates one edge from repeated edges.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [1:0] {
        PM_HIGH    = 2'b00,
        PM_SLEEP   = 2'b01,
        PM_SUSPEND = 2'b10,
        PM_OFF     = 2'b11
    } pm_mode_e;

    localparam int NUM_EV     = 2;
    localparam int EV_RESUME  = 0;
    localparam int EV_SUSPEND = 1;

    localparam int IDX_MODE   = 0;
    localparam int IDX_STATUS = 1;
    localparam int IDX_EVENT  = 2;

    typedef struct packed {
        logic suspend;
        logic resume;
    } pm_events_t;

    function automatic logic is_low_power(input pm_mode_e m);
        return m != PM_HIGH;
    endfunction

endpackage

// File: rtl/btn_edge.sv
module btn_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_async,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= btn_async;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[STAGES-2:0], btn_async};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[STAGES-1];
    end

    assign rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/pm_mode_fsm.sv
module pm_mode_fsm
    import pm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       btn_rise,
    input  logic       refresh_stb,
    input  logic       mode_wr,
    input  logic [1:0] mode_wdata,
    output pm_mode_e   mode,
    output pm_events_t ev_set
);
    logic wake_pend;
    logic take_resume;

    assign take_resume    = is_low_power(mode) && !wake_pend;
    assign ev_set.resume  = btn_rise && take_resume;
    assign ev_set.suspend = btn_rise && !take_resume;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode      <= PM_HIGH;
            wake_pend <= 1'b0;
        end else if (btn_rise) begin
            if (take_resume) begin
                wake_pend <= 1'b1;
            end else begin
                mode      <= PM_SUSPEND;
                wake_pend <= 1'b0;
            end
        end else if (wake_pend) begin
            if (refresh_stb) begin
                mode      <= PM_HIGH;
                wake_pend <= 1'b0;
            end
        end else if (mode_wr) begin
            mode <= pm_mode_e'(mode_wdata);
        end
    end
endmodule

// File: rtl/smi_event_reg.sv
module smi_event_reg
    import pm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pm_events_t ev_set,
    input  pm_events_t ev_clr,
    input  logic       status_clr,
    input  logic       handler_done,
    output pm_events_t events,
    output logic       smi_req
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) events <= '0;
        else     events <= (events & ~ev_clr) | ev_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            smi_req <= 1'b0;
            armed   <= 1'b1;
        end else begin
            if (status_clr)   smi_req <= 1'b0;
            if (handler_done) armed   <= 1'b1;
            if (armed && (|events) && !smi_req) begin
                smi_req <= 1'b1;
                armed   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/susres_smi_ctrl.sv
module susres_smi_ctrl
    import pm_pkg::*;
#(
    parameter int IDX_W       = 4,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              btn_in,
    input  logic              refresh_stb,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              handler_done,
    output logic              smi_req,
    output logic [1:0]        mode
);
    localparam logic [IDX_W-1:0] A_MODE   = IDX_W'(IDX_MODE);
    localparam logic [IDX_W-1:0] A_STATUS = IDX_W'(IDX_STATUS);
    localparam logic [IDX_W-1:0] A_EVENT  = IDX_W'(IDX_EVENT);

    logic       acc_edge;
    pm_mode_e   mode_q;
    pm_events_t ev_set, ev_clr, evt_bits;
    logic       wr_mode, wr_status, wr_event;
    logic       unused_wdata_hi;

    assign wr_mode   = reg_wr && (reg_idx == A_MODE);
    assign wr_status = reg_wr && (reg_idx == A_STATUS);
    assign wr_event  = reg_wr && (reg_idx == A_EVENT);
    assign ev_clr    = wr_event ? pm_events_t'(reg_wdata[NUM_EV-1:0]) : '0;
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:2];

    btn_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .btn_async(btn_in),
        .rise     (acc_edge)
    );

    pm_mode_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .btn_rise   (acc_edge),
        .refresh_stb(refresh_stb),
        .mode_wr    (wr_mode),
        .mode_wdata (reg_wdata[1:0]),
        .mode       (mode_q),
        .ev_set     (ev_set)
    );

    smi_event_reg u_evt (
        .clk         (clk),
        .rst         (rst),
        .ev_set      (ev_set),
        .ev_clr      (ev_clr),
        .status_clr  (wr_status),
        .handler_done(handler_done),
        .events      (evt_bits),
        .smi_req     (smi_req)
    );

    assign mode = mode_q;

    always_comb begin
        reg_rdata = '0;
        if (reg_idx == A_MODE)        reg_rdata[1:0]        = mode_q;
        else if (reg_idx == A_STATUS) reg_rdata[0]          = smi_req;
        else if (reg_idx == A_EVENT)  reg_rdata[NUM_EV-1:0] = evt_bits;
    end
endmodule

// File: rtl/susres_smi_chk.sv
module susres_smi_chk #(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_edge,
    input logic              refresh_stb,
    input logic              reg_wr,
    input logic [IDX_W-1:0]  reg_idx,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              handler_done,
    input logic [1:0]        mode,
    input logic [1:0]        evt_bits,
    input logic              smi_req
);
    // R2
    suspend_from_high_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_edge && mode == 2'b00) |=> (mode == 2'b10 && evt_bits[1]));

    // R3
    wake_only_on_refresh_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'b00 && !refresh_stb && !(reg_wr && reg_idx == IDX_W'(0)))
        |=> (mode != 2'b00));

    // R5
    smi_needs_event_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(smi_req) |-> (evt_bits != 2'b00));

    // R5
    smi_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (smi_req && !(reg_wr && reg_idx == IDX_W'(1))) |=> smi_req);

    // R6
    smi_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (smi_req && reg_wr && reg_idx == IDX_W'(1) && !handler_done) |=> !smi_req);

    // R8
    resume_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_bits[0] && !(reg_wr && reg_idx == IDX_W'(2) && reg_wdata[0])) |=> evt_bits[0]);

    // R8
    suspend_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_bits[1] && !(reg_wr && reg_idx == IDX_W'(2) && reg_wdata[1])) |=> evt_bits[1]);
endmodule

bind susres_smi_ctrl susres_smi_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .acc_edge    (acc_edge),
    .refresh_stb (refresh_stb),
    .reg_wr      (reg_wr),
    .reg_idx     (reg_idx),
    .reg_wdata   (reg_wdata),
    .handler_done(handler_done),
    .mode        (mode),
    .evt_bits    (evt_bits),
    .smi_req     (smi_req)
);

// File: tb/tb_susres_smi_ctrl.sv
`timescale 1ns/1ps
module tb_susres_smi_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       btn_in = 1'b0;
    logic       refresh_stb = 1'b0;
    logic [3:0] reg_idx = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       handler_done = 1'b0;
    logic       smi_req;
    logic [1:0] mode;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    susres_smi_ctrl dut (
        .clk(clk), .rst(rst), .btn_in(btn_in), .refresh_stb(refresh_stb),
        .reg_idx(reg_idx), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .handler_done(handler_done),
        .smi_req(smi_req), .mode(mode)
    );

    // op[7:6]: 0 button press, 1 refresh strobe, 2 mode write; arg[5:4]; exp mode[3:2]; exp events[1:0]
    localparam int NV = 16;
    localparam logic [7:0] VEC [NV] = '{
        {2'd0, 2'd0, 2'b10, 2'b10},
        {2'd1, 2'd0, 2'b10, 2'b00},
        {2'd0, 2'd0, 2'b10, 2'b01},
        {2'd1, 2'd0, 2'b00, 2'b00},
        {2'd0, 2'd0, 2'b10, 2'b10},
        {2'd0, 2'd0, 2'b10, 2'b01},
        {2'd0, 2'd0, 2'b10, 2'b10},
        {2'd1, 2'd0, 2'b10, 2'b00},
        {2'd0, 2'd0, 2'b10, 2'b01},
        {2'd1, 2'd0, 2'b00, 2'b00},
        {2'd2, 2'd1, 2'b01, 2'b00},
        {2'd0, 2'd0, 2'b01, 2'b01},
        {2'd1, 2'd0, 2'b00, 2'b00},
        {2'd2, 2'd3, 2'b11, 2'b00},
        {2'd0, 2'd0, 2'b11, 2'b01},
        {2'd1, 2'd0, 2'b00, 2'b00}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press(input int hold);
        @(negedge clk) btn_in = 1'b1;
        cycles(hold);
        btn_in = 1'b0;
        cycles(4);
    endtask

    task automatic refresh();
        @(negedge clk) refresh_stb = 1'b1;
        @(negedge clk) refresh_stb = 1'b0;
        cycles(2);
    endtask

    task automatic wr(input logic [3:0] idx, input logic [7:0] d);
        @(negedge clk) begin reg_idx = idx; reg_wdata = d; reg_wr = 1'b1; end
        @(negedge clk) reg_wr = 1'b0;
        cycles(2);
    endtask

    task automatic rd(input logic [3:0] idx, output logic [7:0] d);
        @(negedge clk) reg_idx = idx;
        #1 d = reg_rdata;
    endtask

    task automatic done_pulse();
        @(negedge clk) handler_done = 1'b1;
        @(negedge clk) handler_done = 1'b0;
        cycles(3);
    endtask

    task automatic service();
        wr(4'd2, 8'h03);
        wr(4'd1, 8'h00);
        done_pulse();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        cycles(3);
        rst = 1'b0;
        cycles(1);
        // R1 reset state
        check("R1 mode", {6'd0, mode}, 8'h00);
        check("R1 smi_req", {7'd0, smi_req}, 8'h00);
        rd(4'd2, d); check("R1 events", d, 8'h00);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][7:6])
                2'd0: press(4);
                2'd1: refresh();
                default: wr(4'd0, {6'd0, VEC[i][5:4]});
            endcase
            check("R2/R3/R4/R10 mode", {6'd0, mode}, {6'd0, VEC[i][3:2]});
            rd(4'd2, d);
            check("R2/R3/R4 events", d, {6'd0, VEC[i][1:0]});
            service();
        end

        // R11 reads
        rd(4'd0, d); check("R11 mode read", d, 8'h00);
        rd(4'd7, d); check("R11 unused index", d, 8'h00);

        // R5 request raised by suspend event
        press(4);
        check("R5 smi raised", {7'd0, smi_req}, 8'h01);
        rd(4'd1, d); check("R11 status read", d, 8'h01);
        // R6 status write drops request
        wr(4'd1, 8'h00);
        check("R6 smi cleared", {7'd0, smi_req}, 8'h00);
        press(4);
        check("R6 no rerequest before done", {7'd0, smi_req}, 8'h00);
        rd(4'd2, d); check("R8 events recorded", d, 8'h03);
        // R8 partial clear
        wr(4'd2, 8'h01);
        rd(4'd2, d); check("R8 partial clear", d, 8'h02);
        // R7 re-arm with pending event
        done_pulse();
        check("R7 smi re-raised", {7'd0, smi_req}, 8'h01);
        service();
        check("R7 no request without events", {7'd0, smi_req}, 8'h00);
        // R10 mode write ignored while wake waits
        wr(4'd0, 8'h01);
        check("R10 mode write ignored", {6'd0, mode}, 2'b10);
        refresh();
        check("R3 wake after refresh", {6'd0, mode}, 2'b00);
        service();

        // R9 long hold is one press
        press(40);
        check("R9 held press suspends", {6'd0, mode}, 2'b10);
        refresh();
        check("R9 single edge only", {6'd0, mode}, 2'b10);
        rd(4'd2, d); check("R9 one event", d, 8'h02);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule